// File: doc/BRIEF.md
# Pre-Trigger Sample Capture Controller

This block records a probe bus into an internal memory of `DEPTH` entries around a single trigger event. A trigger-position register says how many samples taken before the trigger must be kept. After a start request the core first gathers that many samples. It then keeps writing circularly while it waits for a trigger. Once the trigger is seen, it records the remaining entries until the memory holds exactly `DEPTH` samples, and then it stops.

When the capture is complete, a host reads the memory through a logical index. Index 0 is always the oldest stored sample, and the trigger sample sits at the index equal to the trigger position. The address rotation that makes this true is done inside the block, so the host never sees the circular layout.

A start request issued after a capture re-arms the core and clears its pointers. Trigger evaluation, host transport and waveform export are not part of this block.

Top module: `pretrig_capture`

## Requirements
- R1: After reset, `idle_o` is 1 and `armed_o`, `capturing_o` and `done_o` are 0.
- R2: A `start_i` pulse in idle or done latches the trigger position, clamped to `DEPTH-1`. The core then records exactly that many samples before `armed_o` rises. With a position of 0, `armed_o` is high in the cycle right after the start.
- R3: A trigger that arrives while the pre-trigger samples are still being gathered is ignored and does not shift the capture window.
- R4: A trigger seen while armed is stored as a sample. After it, exactly `DEPTH-pos-1` further samples are recorded and `done_o` rises, so `DEPTH-pos` samples are recorded from the trigger on. With `pos = DEPTH-1`, `done_o` is high in the cycle after the trigger.
- R5: In done, `rd_data_o` shows logical entry `rd_addr_i` one clock after the address is applied. Entry 0 is the oldest sample, entries are in time order, and entry `pos` holds the trigger sample.
- R6: Once done, no sample is written, so readback stays the same however long the probe keeps changing.
- R7: A `start_i` pulse in done clears the pointers and runs a fresh capture whose readback follows R5.
- R8: A `start_i` pulse while filling, armed or capturing has no effect.
- R9: The trigger-position register resets to `DEPTH/2`. `pos_wr_i` loads it from `pos_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start / re-arm request |
| trig_i | input | 1 | Trigger condition, already evaluated |
| probe_i | input | WIDTH | Probe bus sampled each clock |
| pos_wr_i | input | 1 | Write strobe for the trigger-position register |
| pos_i | input | $clog2(DEPTH+1) | New trigger position |
| rd_addr_i | input | $clog2(DEPTH) | Logical readback index |
| rd_data_o | output | WIDTH | Readback sample, one cycle latency |
| idle_o | output | 1 | Core is idle |
| armed_o | output | 1 | Pre-trigger window filled, waiting for trigger |
| capturing_o | output | 1 | Recording post-trigger samples |
| done_o | output | 1 | Capture complete, memory frozen |

## Verification
The bench builds the core with `DEPTH = 16` and `WIDTH = 8`. This depth puts every trigger position in reach, including 0, `DEPTH-1`, an out-of-range value that must clamp, and the default of 8. It also lets an armed wait run longer than the whole buffer, so the circular overwrite and the readback rotation are exercised across the wrap point. The probe is a free-running byte counter, so each sample's value tells exactly when it was taken relative to the trigger.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_ARMED = 3'd2,
    ST_CAPT  = 3'd3,
    ST_DONE  = 3'd4
  } cap_state_t;

  // Position limited to the last buffer entry.
  function automatic int unsigned clamp_pos(int unsigned pos, int unsigned depth);
    return (pos > depth - 1) ? depth - 1 : pos;
  endfunction

  // Sum of two buffer addresses, wrapped into 0..depth-1.
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned depth);
    int unsigned s;
    s = a + b;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/pretrig_ctrl.sv
module pretrig_ctrl
  import pretrig_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             trig,
  input  logic             pos_wr,
  input  logic [PW-1:0]    pos_in,
  output cap_state_t       state,
  output logic             wr_en,
  output logic [AW-1:0]    wr_ptr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [PW-1:0] pos_reg;
  logic [AW-1:0] pos_act;
  logic [AW-1:0] pos_start;
  logic [AW-1:0] cnt;
  logic [AW-1:0] ptr_next;
  logic          fill_end;
  logic          capt_end;

  assign pos_start = AW'(clamp_pos(32'(pos_reg), DEPTH));
  assign ptr_next  = (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
  assign wr_en     = (state == ST_FILL) || (state == ST_ARMED) || (state == ST_CAPT);
  assign fill_end  = (cnt == pos_act - AW'(1));
  assign capt_end  = (cnt == AW'(DEPTH - 2) - pos_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_reg <= PW'(DEPTH / 2);
    end else if (pos_wr) begin
      pos_reg <= pos_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wr_ptr  <= '0;
      cnt     <= '0;
      pos_act <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            pos_act <= pos_start;
            wr_ptr  <= '0;
            cnt     <= '0;
            state   <= (pos_start == '0) ? ST_ARMED : ST_FILL;
          end
        end
        ST_FILL: begin
          wr_ptr <= ptr_next;
          if (fill_end) begin
            cnt   <= '0;
            state <= ST_ARMED;
          end else begin
            cnt <= cnt + AW'(1);
          end
        end
        ST_ARMED: begin
          wr_ptr <= ptr_next;
          if (trig) begin
            cnt   <= '0;
            state <= (pos_act == LAST) ? ST_DONE : ST_CAPT;
          end
        end
        ST_CAPT: begin
          wr_ptr <= ptr_next;
          if (capt_end) begin
            state <= ST_DONE;
          end else begin
            cnt <= cnt + AW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pretrig_ram.sv
module pretrig_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/pretrig_rotate.sv
module pretrig_rotate
  import pretrig_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0] logical,
  input  logic [AW-1:0] oldest,
  output logic [AW-1:0] physical
);

  assign physical = AW'(wrap_add(32'(logical), 32'(oldest), DEPTH));

endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture
  import pretrig_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             trig_i,
  input  logic [WIDTH-1:0] probe_i,
  input  logic             pos_wr_i,
  input  logic [PW-1:0]    pos_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             idle_o,
  output logic             armed_o,
  output logic             capturing_o,
  output logic             done_o
);

  cap_state_t    state_w;
  logic          wr_en_w;
  logic [AW-1:0] wr_ptr_w;
  logic [AW-1:0] rd_phys_w;
  logic          filling_w;

  pretrig_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_i),
    .trig   (trig_i),
    .pos_wr (pos_wr_i),
    .pos_in (pos_i),
    .state  (state_w),
    .wr_en  (wr_en_w),
    .wr_ptr (wr_ptr_w)
  );

  pretrig_rotate #(.DEPTH(DEPTH)) u_rot (
    .logical  (rd_addr_i),
    .oldest   (wr_ptr_w),
    .physical (rd_phys_w)
  );

  pretrig_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en_w),
    .wr_addr (wr_ptr_w),
    .wr_data (probe_i),
    .rd_addr (rd_phys_w),
    .rd_data (rd_data_o)
  );

  assign idle_o      = (state_w == ST_IDLE);
  assign armed_o     = (state_w == ST_ARMED);
  assign capturing_o = (state_w == ST_CAPT);
  assign done_o      = (state_w == ST_DONE);
  assign filling_w   = (state_w == ST_FILL);

endmodule

// File: rtl/pretrig_capture_chk.sv
module pretrig_capture_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic trig_i,
  input logic idle_o,
  input logic armed_o,
  input logic capturing_o,
  input logic done_o,
  input logic filling,
  input logic wr_en
);

  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({idle_o, filling, armed_o, capturing_o, done_o})); // R1

  AST_FILL_IGNORES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    filling && trig_i |=> !capturing_o && !done_o); // R3

  AST_TRIG_LEAVES_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o && trig_i |=> capturing_o || done_o); // R4

  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_en); // R6

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o); // R6

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && start_i |=> !done_o && !idle_o); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o || capturing_o || filling) && start_i |=> !idle_o && (!done_o || $past(capturing_o))); // R8

endmodule

bind pretrig_capture pretrig_capture_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .trig_i      (trig_i),
  .idle_o      (idle_o),
  .armed_o     (armed_o),
  .capturing_o (capturing_o),
  .done_o      (done_o),
  .filling     (filling_w),
  .wr_en       (wr_en_w)
);

// File: tb/pretrig_capture_bench.sv
module pretrig_capture_bench;

  localparam int WIDTH = 8;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);

  // Vector fields: {position, armed wait, early trigger flag}
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'd3,  8'd2,  8'd1},
    {8'd0,  8'd0,  8'd0},
    {8'd15, 8'd2,  8'd0},
    {8'd16, 8'd1,  8'd0},
    {8'd1,  8'd5,  8'd0},
    {8'd5,  8'd20, 8'd1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             trig_i = 1'b0;
  logic [WIDTH-1:0] probe_i = '0;
  logic             pos_wr_i = 1'b0;
  logic [PW-1:0]    pos_i = '0;
  logic [AW-1:0]    rd_addr_i = '0;
  logic [WIDTH-1:0] rd_data_o;
  logic             idle_o, armed_o, capturing_o, done_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always @(negedge clk) probe_i <= probe_i + 8'd1;

  pretrig_capture #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_pretrig_capture (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .trig_i(trig_i),
    .probe_i(probe_i), .pos_wr_i(pos_wr_i), .pos_i(pos_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .idle_o(idle_o),
    .armed_o(armed_o), .capturing_o(capturing_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // One full capture; exp_pos is the clamped position the bench expects.
  task automatic run_capture(input int pos, input bit wr_pos, input int waitn,
                             input bit early, input int exp_pos);
    int n;
    logic [WIDTH-1:0] tval;
    @(negedge clk);
    if (wr_pos) begin
      pos_wr_i = 1'b1;
      pos_i = PW'(pos);
      @(negedge clk);
      pos_wr_i = 1'b0;
    end
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(!done_o && !idle_o, "R7 start leaves idle/done", done_o, 0);
    if (early) trig_i = 1'b1;
    n = 0;
    while (!armed_o) begin
      @(negedge clk);
      trig_i = 1'b0;
      n++;
    end
    trig_i = 1'b0;
    chk(n == exp_pos, "R2 pre-trigger fill length", n, exp_pos);
    for (int k = 0; k < waitn; k++) begin
      start_i = (k == 0);
      @(negedge clk);
      start_i = 1'b0;
      chk(armed_o, "R8 start ignored while armed", armed_o, 1);
    end
    trig_i = 1'b1;
    @(posedge clk);
    tval = probe_i;
    @(negedge clk);
    trig_i = 1'b0;
    n = 0;
    while (!done_o) begin
      start_i = (n == 0);
      @(negedge clk);
      start_i = 1'b0;
      n++;
    end
    chk(n == DEPTH - exp_pos - 1, "R4 post-trigger length", n, DEPTH - exp_pos - 1);
    repeat (7) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      logic [WIDTH-1:0] expv;
      expv = tval - WIDTH'(exp_pos) + WIDTH'(i);
      rd_addr_i = AW'(i);
      @(negedge clk);
      chk(rd_data_o == expv, (i == exp_pos) ? "R5 trigger entry" : "R5 R6 time-ordered readback",
          rd_data_o, expv);
    end
    chk(done_o, "R6 stays done", done_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(idle_o && !armed_o && !capturing_o && !done_o, "R1 reset status",
        {idle_o, armed_o, capturing_o, done_o}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle_o, "R1 idle after reset release", idle_o, 1);
    // R9 default position DEPTH/2, with an early trigger for R3
    run_capture(0, 1'b0, 3, 1'b1, DEPTH / 2);
    for (int v = 0; v < NV; v++) begin
      int p;
      p = int'(VEC[v][23:16]);
      run_capture(p, 1'b1, int'(VEC[v][15:8]), VEC[v][0],
                  (p > DEPTH - 1) ? DEPTH - 1 : p);
    end
    // R3 directed: trigger held during fill of position 6
    run_capture(6, 1'b1, 0, 1'b1, 6);
    finish_run();
  end

endmodule